// File: doc/BRIEF.md
# APB Bridge Peripheral Security Filter

This block is the front end of a bridge from a single-beat request port to a peripheral bus with several select lines. The peripheral bus carries no security indication, so unmodified peripherals attach to it directly. The bridge enforces security on their behalf. Every request carries a non-secure flag. The bridge decodes the target slot from the address and compares the flag with a per-peripheral attribute held in a configuration vector. A request that fails the check never reaches the peripheral bus and is answered upstream with an error. A request that passes runs a normal setup/access transfer on the peripheral bus and honours any wait states the peripheral inserts.

The configuration vector is a register inside the bridge and is reached through the same request port at a reserved slot. Only secure writes can change it. A build-time mask marks peripherals that stay open to non-secure requests whatever the vector holds. Debug-infrastructure slaves are the usual use for this mask.

Both request and response use valid/ready. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only when the bridge is idle, so one transfer is outstanding at a time. Once `rsp_valid` rises, it stays high with `rsp_rdata` and `rsp_err` unchanged until a cycle where `rsp_ready` is high. The upstream side may hold `rsp_ready` low for as long as it needs.

Top module: `apb_sec_filter`

## Requirements
- R1: After reset, all selects and `penable` are low, `rsp_valid` is low, `req_ready` is high, and the configuration vector is all ones (every peripheral secure-only).
- R2: Address bits [14:12] form the slot. Slots 0 to 3 select peripherals 0 to 3, and slot 4 is the configuration register. Slots 5 to 7 get an error response with zero data and cause no select activity.
- R3: A secure request (`req_nonsec`=0) to any peripheral slot is forwarded to that peripheral.
- R4: A non-secure request to peripheral i where vector bit i is 1 and i is not in the open mask is rejected. The bridge raises no select for it, and the error response with zero data appears in the cycle after acceptance.
- R5: Peripherals in the open mask (default: peripheral 3) accept non-secure requests whatever their vector bit holds. Peripherals whose vector bit is 0 also accept non-secure requests.
- R6: A forwarded transfer spends one cycle with a one-hot select and `penable` low, then raises `penable`. The select, `paddr`, `pwrite` and `pwdata` stay stable until the cycle in which `pready` is high.
- R7: The response of a forwarded transfer takes `rsp_err` from `pslverr`. It takes `rsp_rdata` from `prdata` for reads and returns zero for writes.
- R8: A secure write to slot 4 loads `req_wdata[3:0]` into the vector and returns no error. A non-secure write to slot 4 leaves the vector unchanged and returns an error. Reads of slot 4 from either world return the vector zero-extended, with no error.
- R9: `req_ready` is high only while no transfer is outstanding. `rsp_valid`, `rsp_rdata` and `rsp_err` stay held until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_addr | input | 16 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_nonsec | input | 1 | 1 = non-secure request, 0 = secure |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Upstream accepts the response |
| rsp_rdata | output | 32 | Read data of the response |
| rsp_err | output | 1 | Error response |
| psel | output | 4 | Peripheral select, one bit per peripheral |
| penable | output | 1 | Access phase strobe |
| paddr | output | 16 | Peripheral address |
| pwrite | output | 1 | Peripheral write |
| pwdata | output | 32 | Peripheral write data |
| prdata | input | 32 | Read data from the selected peripheral |
| pready | input | 1 | Peripheral completes the access |
| pslverr | input | 1 | Peripheral error |

## Verification
The hardest situation to reach is a non-secure request to a peripheral whose attribute was changed a few transfers earlier. It depends on a secure write landing in the vector before the request that tests it. The random stream therefore mixes secure and non-secure configuration writes with peripheral accesses. This keeps the vector moving through many values while a bench model tracks it. Peripheral wait states, peripheral errors and response back-pressure are drawn at random on every cycle, so the hold rules are exercised under long stalls as well.

// File: rtl/apbsf_pkg.sv
package apbsf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_RESP   = 2'd3
  } apbsf_state_e;
endpackage

// File: rtl/apbsf_decode.sv
module apbsf_decode #(
  parameter int           N         = 4,
  parameter int           SLOT_W    = 3,
  parameter logic [N-1:0] OPEN_MASK = '0
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic              nonsec,
  input  logic [N-1:0]      cfg,
  output logic [N-1:0]      sel_onehot,
  output logic              is_periph,
  output logic              is_cfg,
  output logic              allowed
);
  logic [N-1:0] locked;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign sel_onehot[i] = (slot == SLOT_W'(i));
    // a peripheral is closed to non-secure requests when its bit is set
    // and it is not one of the always-open slots
    assign locked[i]     = cfg[i] & ~OPEN_MASK[i];
  end

  assign is_periph = (slot < SLOT_W'(N));
  assign is_cfg    = (slot == SLOT_W'(N));
  assign allowed   = is_periph & (~nonsec | ~|(sel_onehot & locked));
endmodule

// File: rtl/apbsf_cfg_reg.sv
module apbsf_cfg_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '1;
    else if (wr_en) cfg_q <= wr_data;
  end
endmodule

// File: rtl/apbsf_seq.sv
module apbsf_seq
  import apbsf_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_apb,
  input  logic              start_local,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_write,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [N-1:0]      in_sel,
  input  logic [DATA_W-1:0] local_rdata,
  input  logic              local_err,
  output logic              idle,
  output logic [N-1:0]      psel,
  output logic              penable,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pready,
  input  logic              pslverr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  apbsf_state_e state_q;
  logic [N-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sel_q     <= '0;
      paddr     <= '0;
      pwrite    <= 1'b0;
      pwdata    <= '0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_apb) begin
            state_q <= ST_SETUP;
            sel_q   <= in_sel;
            paddr   <= in_addr;
            pwrite  <= in_write;
            pwdata  <= in_wdata;
          end else if (start_local) begin
            state_q   <= ST_RESP;
            rsp_rdata <= local_rdata;
            rsp_err   <= local_err;
          end
        end
        ST_SETUP: state_q <= ST_ACCESS;
        ST_ACCESS: begin
          if (pready) begin
            state_q   <= ST_RESP;
            rsp_rdata <= pwrite ? '0 : prdata;
            rsp_err   <= pslverr;
          end
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign psel      = (state_q == ST_SETUP || state_q == ST_ACCESS) ? sel_q : '0;
  assign penable   = (state_q == ST_ACCESS);
  assign rsp_valid = (state_q == ST_RESP);
endmodule

// File: rtl/apb_sec_filter.sv
module apb_sec_filter #(
  parameter int           N         = 4,
  parameter int           ADDR_W    = 16,
  parameter int           DATA_W    = 32,
  parameter int           SLOT_LSB  = 12,
  parameter logic [N-1:0] OPEN_MASK = 4'b1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_nonsec,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [N-1:0]      psel,
  output logic              penable,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pready,
  input  logic              pslverr
);
  localparam int SLOT_W = $clog2(N + 1);

  logic [N-1:0] cfg_q, sel_onehot;
  logic is_periph, is_cfg, allowed, idle, accept;
  logic start_apb, start_local, local_err, cfg_we;
  logic [DATA_W-1:0] local_rdata;

  apbsf_decode #(.N(N), .SLOT_W(SLOT_W), .OPEN_MASK(OPEN_MASK)) u_dec (
    .slot(req_addr[SLOT_LSB +: SLOT_W]), .nonsec(req_nonsec), .cfg(cfg_q),
    .sel_onehot(sel_onehot), .is_periph(is_periph), .is_cfg(is_cfg),
    .allowed(allowed)
  );

  assign req_ready   = idle;
  assign accept      = req_valid & idle;
  assign start_apb   = accept & allowed;
  assign start_local = accept & ~allowed;
  assign cfg_we      = accept & is_cfg & req_write & ~req_nonsec;
  // everything answered locally is an error except a config read or a secure config write
  assign local_err   = ~is_cfg | (req_write & req_nonsec);
  assign local_rdata = (is_cfg & ~req_write) ? DATA_W'(cfg_q) : '0;

  apbsf_cfg_reg #(.N(N)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(req_wdata[N-1:0]),
    .cfg_q(cfg_q)
  );

  apbsf_seq #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_apb(start_apb), .start_local(start_local),
    .in_addr(req_addr), .in_write(req_write), .in_wdata(req_wdata),
    .in_sel(sel_onehot), .local_rdata(local_rdata), .local_err(local_err),
    .idle(idle), .psel(psel), .penable(penable), .paddr(paddr),
    .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );
endmodule

// File: rtl/apb_sec_filter_chk.sv
module apb_sec_filter_chk #(
  parameter int           N         = 4,
  parameter int           ADDR_W    = 16,
  parameter int           DATA_W    = 32,
  parameter int           SLOT_LSB  = 12,
  parameter logic [N-1:0] OPEN_MASK = 4'b1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_nonsec,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic [N-1:0]      psel,
  input logic              penable,
  input logic [ADDR_W-1:0] paddr,
  input logic              pready,
  input logic [N-1:0]      cfg_q
);
  localparam int SLOT_W = $clog2(N + 1);
  logic reject_now;

  always_comb begin
    reject_now = 1'b0;
    for (int i = 0; i < N; i++)
      if (req_addr[SLOT_LSB +: SLOT_W] == SLOT_W'(i) && cfg_q[i] && !OPEN_MASK[i])
        reject_now = req_valid && req_ready && req_nonsec;
  end

  assert_reject_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reject_now |=> (rsp_valid && rsp_err && rsp_rdata == '0 && psel == '0));
  assert_psel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(psel));
  assert_enable_needs_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> (psel != '0));
  assert_setup_to_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((psel != '0) && !penable) |=> (penable && psel == $past(psel)));
  assert_access_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (penable && !pready) |=> (penable && $stable(psel) && $stable(paddr)));
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && psel == '0));
endmodule

bind apb_sec_filter apb_sec_filter_chk #(
  .N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_LSB(SLOT_LSB), .OPEN_MASK(OPEN_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_nonsec(req_nonsec), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .psel(psel), .penable(penable), .paddr(paddr), .pready(pready), .cfg_q(cfg_q)
);

// File: tb/apb_sec_filter_tb_top.sv
module apb_sec_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] OPEN = 4'b1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_nonsec = 0, rsp_ready = 0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0, prdata = '0;
  logic pready = 0, pslverr = 0;
  logic req_ready, rsp_valid, rsp_err, penable, pwrite;
  logic [31:0] rsp_rdata, pwdata;
  logic [3:0] psel;
  logic [15:0] paddr;

  int checks = 0, fails = 0;
  int setup_cnt;
  logic [3:0] seen_sel;
  logic [15:0] seen_addr;
  logic seen_write;
  logic [31:0] seen_wdata, exp_prdata;
  logic exp_slverr;
  logic [3:0] cfg_m = 4'hF;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  apb_sec_filter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_nonsec(req_nonsec), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .psel(psel), .penable(penable),
    .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // peripheral model: observes the bus and picks wait states / data for the next edge
  always @(negedge clk) begin
    if (psel != 0 && !penable) begin
      setup_cnt++;
      seen_sel = psel; seen_addr = paddr; seen_write = pwrite; seen_wdata = pwdata;
    end
    if (psel != 0 && penable)
      chk(psel == seen_sel && paddr == seen_addr && pwrite == seen_write &&
          pwdata == seen_wdata, "R6", "access phase hold", {28'd0, psel}, {28'd0, seen_sel});
    pready  = ($urandom % 3) == 0;
    prdata  = $urandom;
    pslverr = ($urandom % 4) == 0;
    if (psel != 0 && penable && pready) begin
      exp_prdata = prdata; exp_slverr = pslverr;
    end
  end

  function automatic bit allowed_m(logic [2:0] slot, logic ns);
    return !ns || !cfg_m[slot] || OPEN[slot];
  endfunction

  task automatic txn(logic [2:0] slot, logic [11:0] low, logic wr, logic [31:0] wd, logic ns);
    logic [15:0] a = {1'b0, slot, low};
    bit periph = slot < 4;
    bit fwd = periph && allowed_m(slot, ns);
    logic [31:0] er, hr; logic ee, he;
    string rq = !periph ? (slot == 4 ? "R8" : "R2") : (fwd ? (ns ? "R5" : "R3") : "R4");
    @(negedge clk);
    chk(req_ready, "R9", "ready when idle", {31'd0, req_ready}, 1);
    req_valid = 1; req_addr = a; req_write = wr; req_wdata = wd; req_nonsec = ns;
    setup_cnt = 0;
    @(negedge clk);
    req_valid = 0;
    if (!fwd) chk(rsp_valid, rq, "local response one cycle after accept", {31'd0, rsp_valid}, 1);
    for (int i = 0; i < 60 && !rsp_valid; i++) @(negedge clk);
    if (fwd) begin
      er = wr ? 32'd0 : exp_prdata; ee = exp_slverr;
    end else if (slot == 4) begin
      er = wr ? 32'd0 : {28'd0, cfg_m}; ee = wr && ns;
      if (wr && !ns) cfg_m = wd[3:0];
    end else begin
      er = 0; ee = 1;
    end
    hr = rsp_rdata; he = rsp_err;
    for (int k = $urandom % 4; k > 0; k--) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == hr && rsp_err == he, "R9", "response held", rsp_rdata, hr);
    end
    chk(rsp_valid, rq, "response valid", {31'd0, rsp_valid}, 1);
    chk(rsp_rdata == er, fwd ? "R7" : rq, "rdata", rsp_rdata, er);
    chk(rsp_err == ee, fwd ? "R7" : rq, "err", {31'd0, rsp_err}, {31'd0, ee});
    chk(setup_cnt == (fwd ? 1 : 0), rq, "setup count", setup_cnt, fwd ? 1 : 0);
    if (fwd)
      chk(seen_sel == (4'b1 << slot) && seen_addr == a && seen_write == wr &&
          (!wr || seen_wdata == wd), "R6", "setup fields", {28'd0, seen_sel}, {28'd0, 4'b1 << slot});
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(!rsp_valid && req_ready, "R9", "return to idle", {31'd0, rsp_valid}, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EC0_F17E));
    #(CLK_PERIOD * 3);
    chk(psel == 0 && !penable && !rsp_valid && req_ready, "R1", "reset outputs",
        {28'd0, psel}, 0);
    @(negedge clk); rst_n = 1;
    txn(3'd4, 12'h0, 0, 0, 1);              // R1 all-secure vector, R8 read from non-secure
    txn(3'd0, 12'h010, 0, 0, 1);            // R4 locked peripheral
    txn(3'd2, 12'h020, 1, 32'hABCD, 1);     // R4 write is rejected too
    txn(3'd3, 12'h030, 0, 0, 1);            // R5 open peripheral
    txn(3'd1, 12'h040, 1, 32'h1234_5678, 0);// R3 secure write
    txn(3'd4, 12'h0, 1, 32'h0, 1);          // R8 non-secure write ignored
    txn(3'd4, 12'h0, 0, 0, 0);              // R8 readback unchanged
    txn(3'd4, 12'h0, 1, 32'h5, 0);          // R8 secure write
    txn(3'd4, 12'h0, 0, 0, 1);
    txn(3'd1, 12'h050, 0, 0, 1);            // R5 unlocked peripheral now open
    txn(3'd0, 12'h060, 0, 0, 1);            // R4 still locked
    txn(3'd6, 12'h070, 0, 0, 0);            // R2 unmapped slot
    txn(3'd7, 12'hFFF, 1, 32'h1, 1);        // R2
    for (int n = 0; n < 400; n++)
      txn(3'($urandom % 7), 12'($urandom), 1'($urandom), $urandom, 1'($urandom));
    finish_run();
  end
endmodule